// File: doc/BRIEF.md
# Sector Lock Controller

This block keeps two protection bits for every sector of a sectored non-volatile array. One is a soft lock that software can set and clear. The other is a hard lock that software can set but only a reset can clear. Decoded lock commands arrive with a sector index and update those bits on the clock edge.

A combinational query port takes a request kind (single sector, plane, or whole chip) and a sector index. It returns whether the program or erase may go ahead, and a mask of the sectors the operation would touch. A write-protect pin decides whether hard locks are enforced. A program-voltage indicator vetoes every write.

A second index selects a sector whose two lock bits are presented for identification-mode reads. The command decoder and the array itself sit outside this block.

Top module: `sector_lock_ctrl`

## Requirements
- R1: While rst_ni is low and after it is released, every sector reads soft lock = 1 and hard lock = 0.
- R2: An unlock command (cmd_op_i = 1) clears the soft lock of the sector given by cmd_sector_i and of no other sector.
- R3: A softlock command (cmd_op_i = 2) sets the soft lock, and a hardlock command (cmd_op_i = 3) sets the hard lock, of the addressed sector only.
- R4: An unlock aimed at a sector whose hard lock is set, issued while wp_i is low, leaves that sector's soft lock unchanged. Such a sector is refused while wp_i is low.
- R5: While wp_i is high the hard lock is ignored. Unlock clears the soft lock even with the hard lock set, and a sector with only the hard lock set is allowed.
- R6: Once set, a hard lock falls only through reset. Unlock and wp_i do not clear it.
- R7: While vpp_ok_i is low, allow_o is 0 and erase_mask_o is all zeros for every query kind.
- R8: id_status_o bit 0 is the soft lock and bit 1 is the hard lock of the sector on id_sector_i.
- R9: A plane query (query_kind_i = 1) is allowed only if no sector in the plane that contains query_sector_i is protected. Planes are equal runs of consecutive sector numbers. When allowed, erase_mask_o covers the whole plane; when refused, it is zero.
- R10: A chip query (query_kind_i = 2) is allowed whenever vpp_ok_i is high. erase_mask_o then holds exactly the unprotected sectors, so protected sectors are skipped.
- R11: A sector query (query_kind_i = 0) is allowed only if that sector is unprotected, and its mask is then one-hot on that sector. Query kind 3 is never allowed. A command with cmd_valid_i low or cmd_op_i = 0 changes no lock bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Lock command strobe |
| cmd_op_i | input | 2 | 0 none, 1 unlock, 2 softlock, 3 hardlock |
| cmd_sector_i | input | SECT_W | Sector addressed by the command |
| wp_i | input | 1 | Write-protect pin; high overrides hard locks |
| vpp_ok_i | input | 1 | Program voltage adequate |
| query_kind_i | input | 2 | 0 sector, 1 plane, 2 chip, 3 none |
| query_sector_i | input | SECT_W | Sector (or any sector of the plane) being queried |
| id_sector_i | input | SECT_W | Sector whose lock status is read |
| allow_o | output | 1 | Requested program/erase may proceed |
| erase_mask_o | output | NUM_SECTORS | Sectors the request would modify |
| id_status_o | output | 2 | {hard lock, soft lock} of id_sector_i |

## Verification
The bench targets the lock interplay around write-protect. It tries unlock on a hard-locked sector with wp_i low, where a design that ignored the hard lock would clear the soft bit. It tries unlock with wp_i high, where a design that still honoured the hard lock would keep the sector read-only. It then drops wp_i again, where a design that cleared the hard bit along with the soft one would leave the sector writable.

Plane queries are aimed at a plane holding a single protected sector and at a fully locked plane; a wrong range decode would allow or refuse the wrong plane. Chip queries are checked with wp_i both low and high, where a design that refused the whole chip, or erased through a lock, gives a wrong mask. A mid-run reset confirms that hard locks fall and soft locks return.

// File: rtl/sector_lock_pkg.sv
package sector_lock_pkg;

  typedef enum logic [1:0] {
    LK_NOP    = 2'd0,
    LK_UNLOCK = 2'd1,
    LK_SOFT   = 2'd2,
    LK_HARD   = 2'd3
  } lock_op_e;

  typedef enum logic [1:0] {
    Q_SECTOR = 2'd0,
    Q_PLANE  = 2'd1,
    Q_CHIP   = 2'd2,
    Q_NONE   = 2'd3
  } query_e;

endpackage

// File: rtl/lock_bank.sv
module lock_bank
  import sector_lock_pkg::*;
#(
  parameter int NUM_SECTORS = 16,
  parameter int SECT_W      = $clog2(NUM_SECTORS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cmd_valid_i,
  input  lock_op_e               cmd_op_i,
  input  logic [SECT_W-1:0]      cmd_sector_i,
  input  logic                   wp_i,
  output logic [NUM_SECTORS-1:0] soft_o,
  output logic [NUM_SECTORS-1:0] hard_o
);

  for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_sec
    logic sel;
    logic soft_q, hard_q;

    assign sel = cmd_valid_i && (cmd_sector_i == SECT_W'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        soft_q <= 1'b1;
        hard_q <= 1'b0;
      end else if (sel) begin
        unique case (cmd_op_i)
          // hard lock blocks unlock unless the pin overrides it
          LK_UNLOCK: if (!hard_q || wp_i) soft_q <= 1'b0;
          LK_SOFT:   soft_q <= 1'b1;
          LK_HARD:   hard_q <= 1'b1;
          default:   ;
        endcase
      end
    end

    assign soft_o[s] = soft_q;
    assign hard_o[s] = hard_q;
  end

endmodule

// File: rtl/lock_eval.sv
module lock_eval #(
  parameter int NUM_SECTORS = 16
) (
  input  logic [NUM_SECTORS-1:0] soft_i,
  input  logic [NUM_SECTORS-1:0] hard_i,
  input  logic                   wp_i,
  output logic [NUM_SECTORS-1:0] prot_o
);

  assign prot_o = soft_i | (hard_i & {NUM_SECTORS{~wp_i}});

endmodule

// File: rtl/lock_query.sv
module lock_query
  import sector_lock_pkg::*;
#(
  parameter int NUM_SECTORS = 16,
  parameter int NUM_PLANES  = 4,
  parameter int SECT_W      = $clog2(NUM_SECTORS)
) (
  input  logic [NUM_SECTORS-1:0] prot_i,
  input  logic [NUM_SECTORS-1:0] soft_i,
  input  logic [NUM_SECTORS-1:0] hard_i,
  input  logic                   vpp_ok_i,
  input  query_e                 kind_i,
  input  logic [SECT_W-1:0]      query_sector_i,
  input  logic [SECT_W-1:0]      id_sector_i,
  output logic                   allow_o,
  output logic [NUM_SECTORS-1:0] mask_o,
  output logic [1:0]             status_o
);

  localparam int SPP = NUM_SECTORS / NUM_PLANES;

  logic [SECT_W-1:0]      q_plane;
  logic [NUM_SECTORS-1:0] in_plane;
  logic [NUM_SECTORS-1:0] one_hot;
  logic                   plane_busy;

  assign q_plane = query_sector_i / SECT_W'(SPP);

  for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_map
    assign in_plane[s] = (SECT_W'(s / SPP) == q_plane);
    assign one_hot[s]  = (SECT_W'(s) == query_sector_i);
  end

  assign plane_busy = |(prot_i & in_plane);

  always_comb begin
    allow_o = 1'b0;
    mask_o  = '0;
    if (vpp_ok_i) begin
      unique case (kind_i)
        Q_SECTOR: begin
          allow_o = ~prot_i[query_sector_i];
          mask_o  = allow_o ? one_hot : '0;
        end
        Q_PLANE: begin
          allow_o = ~plane_busy;
          mask_o  = allow_o ? in_plane : '0;
        end
        Q_CHIP: begin
          allow_o = 1'b1;
          mask_o  = ~prot_i;
        end
        default: ;
      endcase
    end
  end

  assign status_o = {hard_i[id_sector_i], soft_i[id_sector_i]};

endmodule

// File: rtl/sector_lock_ctrl.sv
module sector_lock_ctrl
  import sector_lock_pkg::*;
#(
  parameter int NUM_SECTORS = 16,
  parameter int NUM_PLANES  = 4,
  localparam int SECT_W     = $clog2(NUM_SECTORS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cmd_valid_i,
  input  logic [1:0]             cmd_op_i,
  input  logic [SECT_W-1:0]      cmd_sector_i,
  input  logic                   wp_i,
  input  logic                   vpp_ok_i,
  input  logic [1:0]             query_kind_i,
  input  logic [SECT_W-1:0]      query_sector_i,
  input  logic [SECT_W-1:0]      id_sector_i,
  output logic                   allow_o,
  output logic [NUM_SECTORS-1:0] erase_mask_o,
  output logic [1:0]             id_status_o
);

  logic [NUM_SECTORS-1:0] soft_q;
  logic [NUM_SECTORS-1:0] hard_q;
  logic [NUM_SECTORS-1:0] prot;

  lock_bank #(
    .NUM_SECTORS(NUM_SECTORS),
    .SECT_W     (SECT_W)
  ) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (lock_op_e'(cmd_op_i)),
    .cmd_sector_i(cmd_sector_i),
    .wp_i        (wp_i),
    .soft_o      (soft_q),
    .hard_o      (hard_q)
  );

  lock_eval #(
    .NUM_SECTORS(NUM_SECTORS)
  ) u_eval (
    .soft_i(soft_q),
    .hard_i(hard_q),
    .wp_i  (wp_i),
    .prot_o(prot)
  );

  lock_query #(
    .NUM_SECTORS(NUM_SECTORS),
    .NUM_PLANES (NUM_PLANES),
    .SECT_W     (SECT_W)
  ) u_query (
    .prot_i        (prot),
    .soft_i        (soft_q),
    .hard_i        (hard_q),
    .vpp_ok_i      (vpp_ok_i),
    .kind_i        (query_e'(query_kind_i)),
    .query_sector_i(query_sector_i),
    .id_sector_i   (id_sector_i),
    .allow_o       (allow_o),
    .mask_o        (erase_mask_o),
    .status_o      (id_status_o)
  );

endmodule

// File: rtl/sector_lock_chk.sv
module sector_lock_chk #(
  parameter int NUM_SECTORS = 16,
  parameter int SECT_W      = $clog2(NUM_SECTORS)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   cmd_valid_i,
  input logic [1:0]             cmd_op_i,
  input logic [SECT_W-1:0]      cmd_sector_i,
  input logic                   wp_i,
  input logic                   vpp_ok_i,
  input logic                   allow_o,
  input logic [NUM_SECTORS-1:0] erase_mask_o,
  input logic [NUM_SECTORS-1:0] soft_q,
  input logic [NUM_SECTORS-1:0] hard_q
);

  // R7
  vpp_veto_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vpp_ok_i |-> (!allow_o && erase_mask_o == '0));

  // R6
  hard_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(hard_q) & ~hard_q) == '0);

  // R4
  unlock_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 2'd1 && hard_q[cmd_sector_i] && !wp_i)
    |=> soft_q[$past(cmd_sector_i)] == $past(soft_q[cmd_sector_i]));

  // R5
  unlock_override_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 2'd1 && wp_i) |=> !soft_q[$past(cmd_sector_i)]);

  // R3
  hardlock_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 2'd3) |=> hard_q[$past(cmd_sector_i)]);

  // R10
  mask_respects_soft_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_mask_o & soft_q) == '0);

endmodule

bind sector_lock_ctrl sector_lock_chk #(
  .NUM_SECTORS(NUM_SECTORS),
  .SECT_W     (SECT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .cmd_sector_i(cmd_sector_i),
  .wp_i        (wp_i),
  .vpp_ok_i    (vpp_ok_i),
  .allow_o     (allow_o),
  .erase_mask_o(erase_mask_o),
  .soft_q      (soft_q),
  .hard_q      (hard_q)
);

// File: tb/sector_lock_ctrl_test.sv
module sector_lock_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int NP = 2;
  localparam int SW = 3;
  localparam int NV = 20;

  // {req[4], valid, op[2], sec[3], wp, vpp, kind[2], qsec[3], id[3], allow, status[2], mask[8]}
  localparam logic [30:0] VEC [NV] = '{
    {4'd1,  1'b0,2'd0,3'd0,1'b0,1'b1,2'd0,3'd0,3'd0, 1'b0,2'b01,8'h00}, // R1 locked after reset
    {4'd2,  1'b1,2'd1,3'd1,1'b0,1'b1,2'd0,3'd1,3'd1, 1'b1,2'b00,8'h02}, // R2 unlock s1
    {4'd2,  1'b1,2'd1,3'd2,1'b0,1'b1,2'd0,3'd3,3'd3, 1'b0,2'b01,8'h00}, // R2 neighbour untouched
    {4'd2,  1'b1,2'd1,3'd0,1'b0,1'b1,2'd0,3'd0,3'd0, 1'b1,2'b00,8'h01}, // R2 unlock s0
    {4'd9,  1'b1,2'd1,3'd3,1'b0,1'b1,2'd1,3'd2,3'd3, 1'b1,2'b00,8'h0F}, // R9 plane 0 free
    {4'd9,  1'b1,2'd3,3'd2,1'b0,1'b1,2'd1,3'd1,3'd2, 1'b0,2'b10,8'h00}, // R9 hard lock s2 blocks plane
    {4'd8,  1'b1,2'd2,3'd2,1'b0,1'b1,2'd0,3'd2,3'd2, 1'b0,2'b11,8'h00}, // R8 both bits
    {4'd4,  1'b1,2'd1,3'd2,1'b0,1'b1,2'd0,3'd2,3'd2, 1'b0,2'b11,8'h00}, // R4 unlock ignored
    {4'd5,  1'b0,2'd0,3'd0,1'b1,1'b1,2'd0,3'd2,3'd2, 1'b0,2'b11,8'h00}, // R5 soft still blocks
    {4'd5,  1'b1,2'd1,3'd2,1'b1,1'b1,2'd0,3'd2,3'd2, 1'b1,2'b10,8'h04}, // R5 override unlock
    {4'd6,  1'b0,2'd0,3'd0,1'b0,1'b1,2'd0,3'd2,3'd2, 1'b0,2'b10,8'h00}, // R6 hard survives unlock
    {4'd5,  1'b0,2'd0,3'd0,1'b1,1'b1,2'd1,3'd0,3'd2, 1'b1,2'b10,8'h0F}, // R5 plane with override
    {4'd3,  1'b1,2'd2,3'd0,1'b0,1'b1,2'd0,3'd0,3'd0, 1'b0,2'b01,8'h00}, // R3 softlock s0
    {4'd7,  1'b0,2'd0,3'd0,1'b0,1'b0,2'd0,3'd1,3'd1, 1'b0,2'b00,8'h00}, // R7 sector vetoed
    {4'd10, 1'b0,2'd0,3'd0,1'b0,1'b1,2'd2,3'd0,3'd5, 1'b1,2'b01,8'h0A}, // R10 chip skips locks
    {4'd10, 1'b0,2'd0,3'd0,1'b1,1'b1,2'd2,3'd0,3'd5, 1'b1,2'b01,8'h0E}, // R10 chip with override
    {4'd7,  1'b0,2'd0,3'd0,1'b1,1'b0,2'd2,3'd0,3'd5, 1'b0,2'b01,8'h00}, // R7 chip vetoed
    {4'd11, 1'b0,2'd1,3'd5,1'b0,1'b1,2'd0,3'd5,3'd5, 1'b0,2'b01,8'h00}, // R11 strobe low ignored
    {4'd9,  1'b0,2'd0,3'd0,1'b0,1'b1,2'd1,3'd6,3'd6, 1'b0,2'b01,8'h00}, // R9 plane 1 locked
    {4'd11, 1'b0,2'd0,3'd0,1'b0,1'b1,2'd3,3'd1,3'd1, 1'b0,2'b00,8'h00}  // R11 kind 3 never allowed
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cmd_valid_i = 1'b0;
  logic [1:0]    cmd_op_i = '0;
  logic [SW-1:0] cmd_sector_i = '0;
  logic          wp_i = 1'b0;
  logic          vpp_ok_i = 1'b1;
  logic [1:0]    query_kind_i = '0;
  logic [SW-1:0] query_sector_i = '0;
  logic [SW-1:0] id_sector_i = '0;
  logic          allow_o;
  logic [NS-1:0] erase_mask_o;
  logic [1:0]    id_status_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sector_lock_ctrl #(.NUM_SECTORS(NS), .NUM_PLANES(NP)) uut (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_op_i, .cmd_sector_i, .wp_i, .vpp_ok_i,
    .query_kind_i, .query_sector_i, .id_sector_i,
    .allow_o, .erase_mask_o, .id_status_o
  );

  task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic ea, input logic [1:0] es, input logic [7:0] em);
    check(tag, "allow_o", {7'd0, allow_o}, {7'd0, ea});
    check(tag, "id_status_o", {6'd0, id_status_o}, {6'd0, es});
    check(tag, "erase_mask_o", erase_mask_o, em);
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    // R1: reset state visible while held
    id_sector_i = 3'd7; query_sector_i = 3'd7;
    #1 check_all("R1", 1'b0, 2'b01, 8'h00);
    @(negedge clk_i) rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [30:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[30:27], i);
      @(negedge clk_i);
      cmd_valid_i    = v[26];
      cmd_op_i       = v[25:24];
      cmd_sector_i   = v[23:21];
      wp_i           = v[20];
      vpp_ok_i       = v[19];
      query_kind_i   = v[18:17];
      query_sector_i = v[16:14];
      id_sector_i    = v[13:11];
      @(posedge clk_i);
      #1 cmd_valid_i = 1'b0;
      #(CLK_PERIOD/4);
      check_all(tag, v[10], v[9:8], v[7:0]);
    end

    // R6 / R1: mid-run reset clears the hard lock on sector 2 and relocks the rest
    @(negedge clk_i) rst_ni = 1'b0;
    wp_i = 1'b0; vpp_ok_i = 1'b1;
    query_kind_i = 2'd0; query_sector_i = 3'd1; id_sector_i = 3'd2;
    #1 check_all("R6 reset", 1'b0, 2'b01, 8'h00);
    @(negedge clk_i) rst_ni = 1'b1;
    // R2 after reset: unlock s2 now works with wp_i low since hard lock is gone
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_op_i = 2'd1; cmd_sector_i = 3'd2;
    query_sector_i = 3'd2;
    @(posedge clk_i);
    #1 cmd_valid_i = 1'b0;
    #(CLK_PERIOD/4);
    check_all("R6 post-reset unlock", 1'b1, 2'b00, 8'h04);
    // R3 hardlock on s7 does not touch s6
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_op_i = 2'd3; cmd_sector_i = 3'd7; id_sector_i = 3'd6;
    @(posedge clk_i);
    #1 cmd_valid_i = 1'b0;
    #(CLK_PERIOD/4);
    check("R3", "id_status_o s6", {6'd0, id_status_o}, 8'h01);
    id_sector_i = 3'd7;
    #1 check("R3", "id_status_o s7", {6'd0, id_status_o}, 8'h03);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule